// File: doc/BRIEF.md
# Serial-Parallel-Serial Shift Memory

This block is a block-serial bit store. A serial stream enters at one horizontal step per accepted bit. `COLS` bits accumulate in an input row register. When that row is complete, the whole row moves in parallel into the head of a stack of column registers. The column stack advances only once for every `COLS` accepted bits, so most stored bits sit still between steps. On the same step, the row leaving the bottom of the stack is loaded into an output row register. That register then presents its bits serially, one per accepted input bit, while the next input row fills.

The input row, `ROWS-1` column stages and the output row together hold `COLS*ROWS` bits in flight. The block therefore acts as a delay line of exactly `COLS*ROWS` accepted bits, and bit order is preserved. Time is counted only in accepted bits: cycles with `in_valid` low freeze everything.

A two-state controller tracks priming. `PRIME` is entered at reset. It moves to `STREAM` on the accepted bit that completes the `ROWS`-th row, which is accepted bit number `COLS*ROWS`. `STREAM` is left only through reset. Output valid is produced only in `STREAM`.

Top module: `sps_shift_memory`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_bit` are 0 after that edge.
- R2: After reset, none of the first `COLS*ROWS` accepted bits produces `out_valid`.
- R3: Once `COLS*ROWS` bits have been accepted since reset, every further accepted bit makes `out_valid` high in the cycle after its acceptance edge, for exactly that one cycle.
- R4: When `out_valid` is high for accepted bit number k (counting from 0 after reset), `out_bit` equals accepted bit number k-`COLS*ROWS`. Order is preserved end to end.
- R5: A cycle with `in_valid` low produces no `out_valid` in the next cycle and does not shift any stored bit, so idle gaps do not change the R4 relation.
- R6: A reset in the middle of a stream discards all stored bits and returns the controller to `PRIME`, after which R2 applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Horizontal step clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept `in_bit` at this edge |
| in_bit | input | 1 | Serial data in |
| out_valid | output | 1 | `out_bit` carries a delayed bit this cycle |
| out_bit | output | 1 | Serial data out |

## Verification
The hardest case to provoke is an idle gap that lands exactly on a row boundary, the accept that triggers a column step and output-row load. There, a design that advanced on clock cycles rather than accepted bits would misalign a whole row. The stimulus sends streams whose idle gaps vary in length and are placed at every offset inside a row, including the last position. It then issues a reset partway through a stream and checks that re-priming starts from zero.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [0:0] {
        ST_PRIME  = 1'b0,
        ST_STREAM = 1'b1
    } sps_state_e;
endpackage

// File: rtl/sps_row_in.sv
module sps_row_in #(
    parameter int COLS = 8,
    localparam int PW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic [PW-1:0]   pos,
    input  logic            din,
    output logic [COLS-1:0] row
);
    logic [COLS-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (shift_en) begin
            held_q[pos] <= din;
        end
    end

    // The completing bit joins the row on the same step it arrives.
    assign row = {din, held_q[COLS-2:0]};
endmodule

// File: rtl/sps_columns.sv
module sps_columns #(
    parameter int COLS  = 8,
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [COLS-1:0] head,
    output logic [COLS-1:0] tail
);
    logic [COLS-1:0] stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            logic [COLS-1:0] src;
            if (s == 0) begin : g_head
                assign src = head;
            end else begin : g_link
                assign src = stage_q[s-1];
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (step) begin
                    stage_q[s] <= src;
                end
            end
        end
    endgenerate

    assign tail = stage_q[DEPTH-1];
endmodule

// File: rtl/sps_row_out.sv
module sps_row_out #(
    parameter int COLS = 8,
    localparam int PW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            load_en,
    input  logic [PW-1:0]   pos,
    input  logic [COLS-1:0] load_row,
    output logic            bit_q
);
    logic [COLS-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            bit_q <= 1'b0;
        end else begin
            if (shift_en) begin
                bit_q <= row_q[pos];
            end
            if (load_en) begin
                row_q <= load_row;
            end
        end
    end
endmodule

// File: rtl/sps_shift_memory.sv
module sps_shift_memory #(
    parameter int COLS = 8,
    parameter int ROWS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit
);
    import sps_pkg::*;

    localparam int PW    = $clog2(COLS);
    localparam int RW    = $clog2(ROWS);
    localparam int DEPTH = ROWS - 1;

    sps_state_e      state_q, state_d;
    logic [PW-1:0]   pos_q;
    logic [RW-1:0]   rows_q;
    logic            row_done;
    logic            out_valid_q;
    logic [COLS-1:0] in_row;
    logic [COLS-1:0] bottom_row;

    assign row_done = in_valid && (pos_q == PW'(COLS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (row_done) begin
            pos_q <= '0;
        end else if (in_valid) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q <= '0;
        end else if (row_done && state_q == ST_PRIME) begin
            rows_q <= rows_q + 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: begin
                if (row_done && rows_q == RW'(ROWS - 1)) begin
                    state_d = ST_STREAM;
                end
            end
            ST_STREAM: begin
                state_d = ST_STREAM;
            end
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= in_valid && (state_q == ST_STREAM);
        end
    end

    sps_row_in #(.COLS(COLS)) u_row_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .pos      (pos_q),
        .din      (in_bit),
        .row      (in_row)
    );

    sps_columns #(.COLS(COLS), .DEPTH(DEPTH)) u_columns (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (row_done),
        .head  (in_row),
        .tail  (bottom_row)
    );

    sps_row_out #(.COLS(COLS)) u_row_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .load_en  (row_done),
        .pos      (pos_q),
        .load_row (bottom_row),
        .bit_q    (out_bit)
    );

    assign out_valid = out_valid_q;
endmodule

// File: rtl/sps_shift_memory_chk.sv
module sps_shift_memory_chk #(
    parameter int COLS = 8,
    parameter int ROWS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic out_bit
);
    localparam int LIM = COLS * ROWS + 1;
    localparam int AW  = $clog2(LIM + 1);

    logic [AW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (in_valid && acc_q != AW'(LIM)) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_bit));

    // R2, R6: valid only after a full store of bits since the last reset
    a_r2_primed_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc_q == AW'(LIM)));

    // R3
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_q >= AW'(LIM - 1)) |=> out_valid);

    // R5
    a_r5_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

bind sps_shift_memory sps_shift_memory_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_bit   (out_bit)
);

// File: tb/sps_shift_memory_test.sv
module sps_shift_memory_test;
    localparam int COLS = 8;
    localparam int ROWS = 4;
    localparam int NM   = COLS * ROWS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid;
    logic out_bit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit next_primed = 1'b0;
    bit in_reset = 1'b1;
    int sent = 0;
    string phase_tag = "R2";
    logic hist[$];
    logic exp_q[$];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    sps_shift_memory #(.COLS(COLS), .ROWS(ROWS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Driver: pushes expected items into the scoreboard
    task automatic send_bit(input logic b);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_bit = b;
        next_primed = (sent >= NM);
        sent++;
        hist.push_back(b);
        if (hist.size() > NM) exp_q.push_back(hist.pop_front());
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            next_primed = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        in_reset = 1'b1;
        in_valid = 1'b0;
        next_primed = 1'b0;
        sent = 0;
        hist.delete();
        exp_q.delete();
        @(posedge clk); #2;
        check(out_valid == 1'b0 && out_bit == 1'b0, "R1", {out_valid, out_bit}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        in_reset = 1'b0;
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Monitor: pops and compares as the design produces results
    initial begin
        bit exp_v = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (!in_reset) begin
                check(out_valid == exp_v, phase_tag, out_valid, exp_v);
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4", out_bit, -1);
                    end else begin
                        logic e;
                        e = exp_q.pop_front();
                        check(out_bit == e, "R4", out_bit, e);
                    end
                end
            end
            exp_v = in_valid && rst_n && next_primed;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R2: priming with alternating bits
        phase_tag = "R2";
        for (int i = 0; i < NM; i++) send_bit(logic'(i % 2));
        // R3, R4: back-to-back stream, several patterns
        phase_tag = "R3";
        for (int i = 0; i < NM; i++) send_bit(1'b1);
        for (int i = 0; i < NM; i++) send_bit(logic'((i % COLS) == (i / COLS)));
        for (int i = 0; i < 3 * NM; i++) send_bit(next_rand());
        // R5: gaps at every offset within a row, including row end
        phase_tag = "R5";
        for (int g = 0; g < COLS; g++) begin
            for (int i = 0; i < COLS; i++) begin
                send_bit(next_rand());
                if (i == g) idle(1 + (g % 3));
            end
        end
        for (int i = 0; i < 2 * NM; i++) begin
            send_bit(next_rand());
            if ((i % 5) == 4) idle(2);
        end
        // R6: reset mid-stream, then re-prime
        for (int i = 0; i < NM / 2 + 3; i++) send_bit(next_rand());
        do_reset();
        phase_tag = "R6";
        for (int i = 0; i < NM; i++) send_bit(1'b1);
        phase_tag = "R3";
        for (int i = 0; i < 2 * NM; i++) send_bit(next_rand());
        idle(4);
        check(exp_q.size() == 0, "R4", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule